// File: doc/BRIEF.md
# Instruction Code Word Expander

This pipeline stage sits between instruction fetch and decode in a core that runs compressed code. Fetch delivers tokens. Each token is a 32-bit fetch word plus a 2-bit count that says how to read it. A count of zero marks the word as one plain instruction, which passes through untouched. A count of one to three marks the word as a pack of 8-bit code words in its low bytes. Each code word indexes a 256-entry table of 31-bit stored instructions. The stage widens each stored entry back to 32 bits by placing a zero in the most significant bit. Instructions whose top bit is set are therefore never assigned a code.

Tokens enter through a small input FIFO with a valid/ready handshake. The expansion control reads the head token and writes one restored instruction per cycle into an output FIFO that feeds decode, also with a valid/ready handshake. Plain and coded tokens leave in strict arrival order. A flush input, raised on a branch mispredict, empties both FIFOs and abandons a partly expanded token in one cycle.

The table is filled through a separate address/data/write-enable port while the stage is held in reset. Reset does not clear the table.

Top module: `icw_expander`

## Requirements
- R1: A token with count 0 produces exactly one output instruction, equal bit for bit to its 32-bit word, including words with bit 31 set.
- R2: A code word c produces the output {1'b0, entry[c]}, where entry[c] is the 31-bit value last written to table address c.
- R3: A token with count n (1 to 3) produces exactly n outputs. Code k (k = 0 to n-1) is taken from word bits [8k+7:8k], so the lowest byte comes first. Bytes at or above position n have no effect on the output.
- R4: Outputs appear in the same order as the tokens and codes that produced them, whatever the mix of plain and coded tokens.
- R5: While out_ready is low, no instruction is lost or duplicated, and a presented out_instr stays stable until it is taken.
- R6: A cycle with flush high makes out_valid low in that cycle and the next one. No output derived from a token accepted before the flush ever appears afterwards.
- R7: After reset, out_valid is 0 and in_ready is 1.
- R8: Table writes issued while rst_n is low are kept. A write changes only the addressed entry, and a later reset does not clear the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all queued and in-progress work |
| in_valid | input | 1 | Token offered |
| in_ready | output | 1 | Token accepted this cycle when in_valid is high |
| in_word | input | 32 | Plain instruction or packed code bytes |
| in_ncodes | input | 2 | 0 = plain instruction, 1..3 = number of codes in the low bytes |
| out_valid | output | 1 | Restored instruction present |
| out_ready | input | 1 | Decode takes the instruction |
| out_instr | output | 32 | Restored instruction |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | 8 | Table write address |
| tbl_wdata | input | 31 | Table write data |

## Verification
The assertions assume that in_word, in_ncodes and the table port carry known values whenever in_valid or tbl_we is high. They also assume the table is written only during reset, so no entry changes under a token being expanded. The bench writes the whole table while reset is low and rewrites one entry during a second reset. It changes its inputs only at the falling edge, and it lowers in_valid while flush is high. The sweeps cover every code value, plain words with either top-bit value, both multi-code counts with junk upper bytes, and a mixed stream under pseudo-random out_ready.

// File: rtl/icw_pkg.sv
// Package: shared widths and token layout for the instruction code word expander.
// Assumes fixed 32-bit instructions and 8-bit code words.
package icw_pkg;
    localparam int WORD_W     = 32;
    localparam int CODE_W     = 8;
    localparam int CNT_W      = 2;
    localparam int ENTRY_W    = WORD_W - 1;
    localparam int TBL_DEPTH  = 1 << CODE_W;
    localparam int SLOTS      = WORD_W / CODE_W;

    // One fetch token: count of packed codes (0 = plain) plus the word.
    typedef struct packed {
        logic [CNT_W-1:0]  ncodes;
        logic [WORD_W-1:0] word;
    } token_t;
endpackage

// File: rtl/icw_fifo.sv
// Module: synchronous FIFO with a single-cycle flush.
// Assumes DEPTH is a power of two and the caller never pushes when full
// nor pops when empty. Storage is not reset; pointers are.
module icw_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW:0]      wr_ptr, rd_ptr;

    assign empty = (wr_ptr == rd_ptr);
    assign full  = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
    assign rdata = mem[rd_ptr[AW-1:0]];

    // Pointer update: reset and flush empty the queue, otherwise advance.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr[AW-1:0]] <= wdata;
    end

    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/icw_table.sv
// Module: code word table, one write port and one combinational read port.
// Assumes writes happen only while the stage is held in reset; entries
// are never cleared by reset.
module icw_table #(
    parameter int AW = 8,
    parameter int DW = 31
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Table load.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    a_r8_known_write: assert property (@(posedge clk)
        we |-> !$isunknown({waddr, wdata}));
endmodule

// File: rtl/icw_expand_ctl.sv
// Module: walks the head token one code per cycle, lowest byte first,
// and forms the restored instruction. Pops the token after its last item.
// Assumes the head token is stable while head_valid is high.
module icw_expand_ctl
    import icw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               head_valid,
    input  token_t             head,
    input  logic               out_full,
    input  logic [ENTRY_W-1:0] tbl_rdata,
    output logic [CODE_W-1:0]  tbl_raddr,
    output logic               pop_in,
    output logic               push_out,
    output logic [WORD_W-1:0]  out_word
);
    logic [CNT_W-1:0]  idx;
    logic [CODE_W-1:0] slot [SLOTS];
    logic              plain, last;

    // Split the fetch word into its code byte slots.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slot[g] = head.word[g*CODE_W +: CODE_W];
    end

    assign plain     = (head.ncodes == '0);
    assign last      = plain || (idx == head.ncodes - 1'b1);
    assign tbl_raddr = slot[idx];
    assign push_out  = head_valid && !out_full && !flush;
    assign pop_in    = push_out && last;
    assign out_word  = plain ? head.word : {1'b0, tbl_rdata};

    // Slot index: restart on reset, flush or token completion.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  idx <= '0;
        else if (push_out)    idx <= last ? '0 : idx + 1'b1;
    end

    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !plain) |-> (idx < head.ncodes));
    a_r1_plain_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && plain) |-> (idx == '0));
endmodule

// File: rtl/icw_expander.sv
// Module: top of the expander stage: input FIFO, expansion control,
// code word table and output FIFO toward decode.
// Assumes the table is loaded while rst_n is low.
module icw_expander
    import icw_pkg::*;
#(
    parameter int IN_DEPTH  = 4,
    parameter int OUT_DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               flush,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [WORD_W-1:0]  in_word,
    input  logic [CNT_W-1:0]   in_ncodes,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [WORD_W-1:0]  out_instr,
    input  logic               tbl_we,
    input  logic [CODE_W-1:0]  tbl_addr,
    input  logic [ENTRY_W-1:0] tbl_wdata
);
    localparam int TOK_W = $bits(token_t);

    token_t             in_tok, head;
    logic [TOK_W-1:0]   head_bits;
    logic               in_full, in_empty, out_full, out_empty;
    logic               pop_in, push_out, in_push, out_pop;
    logic [WORD_W-1:0]  exp_word;
    logic [CODE_W-1:0]  tbl_raddr;
    logic [ENTRY_W-1:0] tbl_rdata;

    assign in_tok    = '{ncodes: in_ncodes, word: in_word};
    assign head      = token_t'(head_bits);
    assign in_ready  = !in_full && !flush;
    assign in_push   = in_valid && in_ready;
    assign out_valid = !out_empty && !flush;
    assign out_pop   = out_valid && out_ready;

    icw_fifo #(.WIDTH(TOK_W), .DEPTH(IN_DEPTH)) u_in_q (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(in_push), .wdata(in_tok),
        .pop(pop_in), .rdata(head_bits),
        .full(in_full), .empty(in_empty)
    );

    icw_table #(.AW(CODE_W), .DW(ENTRY_W)) u_table (
        .clk(clk), .we(tbl_we), .waddr(tbl_addr), .wdata(tbl_wdata),
        .raddr(tbl_raddr), .rdata(tbl_rdata)
    );

    icw_expand_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .head_valid(!in_empty), .head(head),
        .out_full(out_full), .tbl_rdata(tbl_rdata),
        .tbl_raddr(tbl_raddr), .pop_in(pop_in),
        .push_out(push_out), .out_word(exp_word)
    );

    icw_fifo #(.WIDTH(WORD_W), .DEPTH(OUT_DEPTH)) u_out_q (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push_out), .wdata(exp_word),
        .pop(out_pop), .rdata(out_instr),
        .full(out_full), .empty(out_empty)
    );

    a_r7_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> !out_valid);
    a_r6_flush_drains: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_valid);
    a_r5_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (flush || (out_valid && $stable(out_instr))));
endmodule

// File: tb/icw_expander_test.sv
`timescale 1ns/1ps
module icw_expander_test;
    logic        clk = 1'b0;
    logic        rst_n, flush, in_valid, out_ready, tbl_we;
    logic        in_ready, out_valid;
    logic [31:0] in_word, out_instr;
    logic [1:0]  in_ncodes;
    logic [7:0]  tbl_addr;
    logic [30:0] tbl_wdata;

    int          checks = 0, errors = 0, cyc = 0;
    int          wr_i = 0, rd_i = 0;
    logic [31:0] expq [0:4095];
    logic [30:0] model [256];
    string       tag = "R7";
    logic        bp_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    icw_expander uut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .in_valid(in_valid), .in_ready(in_ready),
        .in_word(in_word), .in_ncodes(in_ncodes),
        .out_valid(out_valid), .out_ready(out_ready), .out_instr(out_instr),
        .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata)
    );

    always #4 clk = ~clk;

    function automatic logic [30:0] entry_val(int i);
        if (i == 255) return 31'h7FFF_FFFF;
        return 31'((i * 32'h9E37_79B1) ^ 32'h2B4C_1D3E);
    endfunction

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", t, act, exp);
        end
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Pseudo-random backpressure driver.
    always @(negedge clk) begin
        if (bp_en) begin
            lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            out_ready <= lfsr[0] | lfsr[3];
        end
    end

    // Output monitor: every accepted instruction compared against the queue.
    always begin
        @(negedge clk);
        #1;
        if (rst_n && out_valid && out_ready) begin
            if (rd_i >= wr_i) chk(1'b0, {tag, " extra output"}, out_instr, 32'h0);
            else chk(out_instr === expq[rd_i], tag, out_instr, expq[rd_i]);
            rd_i++;
        end
    end

    task automatic send(input logic [31:0] w, input logic [1:0] n);
        @(negedge clk);
        in_valid  = 1'b1;
        in_word   = w;
        in_ncodes = n;
        #1;
        while (!in_ready) begin @(negedge clk); #1; end
        if (n == 2'd0) begin
            expq[wr_i] = w; wr_i++;
        end else begin
            for (int k = 0; k < int'(n); k++) begin
                expq[wr_i] = {1'b0, model[w[8*k +: 8]]}; wr_i++;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain(input string t);
        int n = 0;
        while (rd_i != wr_i && n < 400) begin @(negedge clk); n++; end
        chk(rd_i == wr_i, {t, " all outputs delivered"}, 32'(rd_i), 32'(wr_i));
    endtask

    initial begin
        rst_n = 1'b0; flush = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        tbl_we = 1'b0; tbl_addr = '0; tbl_wdata = '0; in_word = '0; in_ncodes = '0;
        // R8: load the whole table while reset is held.
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            tbl_we = 1'b1; tbl_addr = 8'(i); tbl_wdata = entry_val(i);
            model[i] = entry_val(i);
        end
        @(negedge clk); tbl_we = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk); #1;
        // R7: idle state after reset.
        chk(out_valid == 1'b0, "R7 out_valid after reset", 32'(out_valid), 32'h0);
        chk(in_ready == 1'b1, "R7 in_ready after reset", 32'(in_ready), 32'h1);

        // R2/R8: every code value once, upper bytes junk.
        tag = "R2";
        for (int c = 0; c < 256; c++) send({8'(c * 7), 8'(c ^ 8'h5A), 8'(~c), 8'(c)}, 2'd1);
        drain("R2");

        // R1: plain words, both values of bit 31.
        tag = "R1";
        for (int i = 0; i < 64; i++) send((32'(i) * 32'h0419_8A33) ^ {i[0], 31'h1234_5678}, 2'd0);
        drain("R1");

        // R3: two- and three-code packs, junk in unused bytes.
        tag = "R3";
        for (int k = 0; k < 128; k++)
            send({8'(k * 11 + 3), 8'(k * 3 + 2), 8'(k * 3 + 1), 8'(k * 3)}, 2'(2 + (k % 2)));
        drain("R3");

        // R4: interleaved plain and coded tokens.
        tag = "R4";
        for (int k = 0; k < 60; k++) begin
            if (k % 3 == 0) send(32'h8000_0001 + 32'(k), 2'd0);
            else send({8'hEE, 8'(k + 40), 8'(255 - k), 8'(k)}, 2'(1 + (k % 3)));
        end
        drain("R4");

        // R5: same style of stream under random backpressure.
        tag = "R5";
        bp_en = 1'b1;
        for (int k = 0; k < 120; k++) begin
            if (k % 4 == 1) send(32'hF00D_0000 ^ 32'(k * 977), 2'd0);
            else send(32'(k * 32'h0103_0507), 2'(1 + (k % 3)));
        end
        @(negedge clk); bp_en = 1'b0;
        @(negedge clk); out_ready = 1'b1;
        drain("R5");

        // R6: fill the queues, flush, then check that nothing stale appears.
        tag = "R6";
        out_ready = 1'b0;
        for (int k = 0; k < 6; k++) send(32'(k + 20), 2'd1);
        repeat (3) @(negedge clk);
        flush = 1'b1;
        rd_i = wr_i;
        #1;
        chk(out_valid == 1'b0, "R6 out_valid during flush", 32'(out_valid), 32'h0);
        @(negedge clk); flush = 1'b0; #1;
        chk(out_valid == 1'b0, "R6 out_valid after flush", 32'(out_valid), 32'h0);
        chk(in_ready == 1'b1, "R6 in_ready after flush", 32'(in_ready), 32'h1);
        out_ready = 1'b1;
        send(32'h0000_0302, 2'd2);
        send(32'hCAFE_F00D, 2'd0);
        drain("R6");

        // R8: rewrite one entry under a second reset; neighbours keep values.
        tag = "R8";
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); tbl_we = 1'b1; tbl_addr = 8'd7; tbl_wdata = 31'h1357_9BDF;
        model[7] = 31'h1357_9BDF;
        @(negedge clk); tbl_we = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        send(32'h0008_0706, 2'd3);
        send(32'h0000_0007, 2'd1);
        drain("R8");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule